// File: doc/BRIEF.md
# Tagged Translation Lookaside Buffer

This block is a small, fully associative translation cache. It maps virtual page numbers to physical frame numbers. Every entry carries an address-space tag, so translations that belong to several processes can be held at once. A lookup presents a virtual address, the active address-space tag and the kind of access. One clock later the block answers with hit or miss, the physical address, the permission bits of the entry, and a deny flag when the access breaks those permissions. After a miss, an external page walker writes the missing translation through the fill port. Invalidate commands remove one page, one address space, or every entry. A separate switch strobe marks a change of the active page-table root.

A runtime mode input enables tagging. When tagging is off, the address-space tag is ignored when entries are matched, and every root switch drops all entries that are not global. When tagging is on, entries survive a switch and the tag picks among them. Entries marked global match under any tag and are removed only by the invalidate-everything command. Each entry maps a 4 KB, 2 MB or 1 GB page. Larger pages compare fewer virtual-page bits and take more of their low address bits straight from the virtual address.

Top module: `tagged_tlb`

## Requirements
- R1: `rsp_valid` is high in the cycle after a cycle with `lk_valid` high and low otherwise; it is low after reset.
- R2: With `tag_en`=1, a lookup hits only an entry whose virtual page and address-space tag both equal the request; for a 4 KB entry `rsp_pa` = {frame number, the low 12 address bits}.
- R3: A miss, including any lookup after reset, returns `rsp_hit`=0, `rsp_pa`=0, all permission outputs 0 and `rsp_deny`=0.
- R4: An entry filled with `fl_global`=1 hits under any address-space tag.
- R5: With `tag_en`=0 the tag is ignored when matching, and `sw_valid` removes every non-global entry; with `tag_en`=1, `sw_valid` changes no entry.
- R6: `inv_kind`=0 (page) removes entries that match `inv_vpn` under `inv_asid` (or any tag, if the entry is global or tagging is off); other entries stay.
- R7: `inv_kind`=1 (address space) removes every non-global entry whose tag equals `inv_asid`; global entries stay.
- R8: `inv_kind`=2 (everything) removes all entries, global ones included; `inv_kind`=3 does nothing.
- R9: A fill goes into the lowest-numbered invalid entry. When all entries are valid it replaces the entry at a round-robin pointer, which starts at 0 after reset and advances by one (wrapping) on each such replacement only.
- R10: A fill whose key (virtual page, page size, global bit and, for non-global entries, the tag) equals that of a valid entry overwrites that entry in place; nothing is evicted and the pointer does not move.
- R11: `fl_size` 0 = 4 KB, 1 = 2 MB, 2 = 1 GB. 2 MB entries compare virtual-page bits [35:9] and 1 GB entries bits [35:18]. The physical address is {frame[39:9], VA[20:0]} for 2 MB and {frame[39:18], VA[29:0]} for 1 GB.
- R12: On a hit, `rsp_deny` is 1 exactly when a write meets `rw`=0, a user access meets `us`=0, or an execute meets `nx`=1.
- R13: A lookup reads the contents from before any fill, invalidate or switch in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tag_en | input | 1 | Address-space tagging enabled |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 48 | Lookup virtual address |
| lk_asid | input | 12 | Active address-space tag |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is from user mode |
| lk_exec | input | 1 | Access is an instruction fetch |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_hit | output | 1 | Translation found |
| rsp_pa | output | 52 | Physical address |
| rsp_rw | output | 1 | Entry writable |
| rsp_us | output | 1 | Entry user accessible |
| rsp_nx | output | 1 | Entry not executable |
| rsp_dirty | output | 1 | Entry dirty |
| rsp_deny | output | 1 | Access violates entry permissions |
| fl_valid | input | 1 | Fill strobe |
| fl_vpn | input | 36 | Fill virtual page number |
| fl_asid | input | 12 | Fill address-space tag |
| fl_global | input | 1 | Fill entry is global |
| fl_size | input | 2 | Fill page size code |
| fl_pfn | input | 40 | Fill frame number |
| fl_rw | input | 1 | Fill writable bit |
| fl_us | input | 1 | Fill user bit |
| fl_nx | input | 1 | Fill no-execute bit |
| fl_dirty | input | 1 | Fill dirty bit |
| inv_valid | input | 1 | Invalidate strobe |
| inv_kind | input | 2 | 0 page, 1 address space, 2 everything, 3 none |
| inv_vpn | input | 36 | Page to invalidate |
| inv_asid | input | 12 | Tag to invalidate |
| sw_valid | input | 1 | Page-table root switch |

## Verification
Every lookup result is due exactly one clock after the request edge. A fill, invalidate or switch changes the table at the edge where it is presented, so the earliest lookup that can see it is the one presented in the next cycle, with its answer one clock after that. The bench drives inputs on the falling edge. At each rising edge its model first computes the answer from the table as it stood, then applies that edge's updates. It compares the registered outputs on the next falling edge, so same-cycle fill-and-lookup cases fall out of this order with no special handling.

// File: rtl/tagged_tlb_pkg.sv
package tagged_tlb_pkg;
   typedef enum logic [1:0] {
      PG_4K   = 2'd0,
      PG_2M   = 2'd1,
      PG_1G   = 2'd2,
      PG_RSVD = 2'd3
   } pg_size_e;

   typedef enum logic [1:0] {
      INV_PAGE  = 2'd0,
      INV_SPACE = 2'd1,
      INV_EVERY = 2'd2,
      INV_NONE  = 2'd3
   } inv_kind_e;

   // virtual-page bits ignored by the larger page sizes
   localparam int MID_DROP = 9;
   localparam int TOP_DROP = 18;
endpackage

// File: rtl/tlb_tag_match.sv
module tlb_tag_match
   import tagged_tlb_pkg::*;
#(
   parameter int N      = 16,
   parameter int VPN_W  = 36,
   parameter int ASID_W = 12
) (
   input  logic [N-1:0]             ent_valid,
   input  logic [N-1:0]             ent_glb,
   input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
   input  logic [N-1:0][ASID_W-1:0] ent_asid,
   input  logic [N-1:0][1:0]        ent_size,
   input  logic [VPN_W-1:0]         key_vpn,
   input  logic [ASID_W-1:0]        key_asid,
   input  logic                     any_asid,
   output logic [N-1:0]             hit
);
   for (genvar g = 0; g < N; g++) begin : g_ent
      logic vpn_eq;
      always_comb begin
         case (ent_size[g])
            PG_4K:   vpn_eq = (ent_vpn[g] == key_vpn);
            PG_2M:   vpn_eq = (ent_vpn[g][VPN_W-1:MID_DROP] == key_vpn[VPN_W-1:MID_DROP]);
            PG_1G:   vpn_eq = (ent_vpn[g][VPN_W-1:TOP_DROP] == key_vpn[VPN_W-1:TOP_DROP]);
            default: vpn_eq = 1'b0;
         endcase
      end
      assign hit[g] = ent_valid[g] && vpn_eq &&
                      (ent_glb[g] || any_asid || (ent_asid[g] == key_asid));
   end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
   parameter int N = 16,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     ent_valid,
   input  logic [N-1:0]     dup_hit,
   input  logic             take,
   output logic [IDX_W-1:0] slot
);
   logic [IDX_W-1:0] rr_q;
   logic             use_rr;

   always_comb begin
      slot   = rr_q;
      use_rr = 1'b1;
      for (int i = N-1; i >= 0; i--) begin
         if (!ent_valid[i]) begin
            slot   = IDX_W'(i);
            use_rr = 1'b0;
         end
      end
      for (int i = N-1; i >= 0; i--) begin
         if (dup_hit[i]) begin
            slot   = IDX_W'(i);
            use_rr = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rr_q <= '0;
      else if (take && use_rr)
         rr_q <= (rr_q == IDX_W'(N-1)) ? '0 : rr_q + 1'b1;
   end
endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb
   import tagged_tlb_pkg::*;
#(
   parameter int N      = 16,
   parameter int VPN_W  = 36,
   parameter int ASID_W = 12,
   parameter int PFN_W  = 40,
   parameter int OFS_W  = 12,
   localparam int VA_W  = VPN_W + OFS_W,
   localparam int PA_W  = PFN_W + OFS_W,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tag_en,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_write,
   input  logic              lk_user,
   input  logic              lk_exec,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [PA_W-1:0]   rsp_pa,
   output logic              rsp_rw,
   output logic              rsp_us,
   output logic              rsp_nx,
   output logic              rsp_dirty,
   output logic              rsp_deny,
   input  logic              fl_valid,
   input  logic [VPN_W-1:0]  fl_vpn,
   input  logic [ASID_W-1:0] fl_asid,
   input  logic              fl_global,
   input  logic [1:0]        fl_size,
   input  logic [PFN_W-1:0]  fl_pfn,
   input  logic              fl_rw,
   input  logic              fl_us,
   input  logic              fl_nx,
   input  logic              fl_dirty,
   input  logic              inv_valid,
   input  logic [1:0]        inv_kind,
   input  logic [VPN_W-1:0]  inv_vpn,
   input  logic [ASID_W-1:0] inv_asid,
   input  logic              sw_valid
);
   if (VPN_W <= TOP_DROP) begin : g_bad_vpn
      $error("VPN_W must exceed the 1 GB drop count");
   end
   if (PFN_W <= TOP_DROP) begin : g_bad_pfn
      $error("PFN_W must exceed the 1 GB drop count");
   end
   if (N < 2) begin : g_bad_n
      $error("N must be at least 2");
   end

   logic [N-1:0]             e_valid, e_glb, e_rw, e_us, e_nx, e_dirty;
   logic [N-1:0][VPN_W-1:0]  e_vpn;
   logic [N-1:0][ASID_W-1:0] e_asid;
   logic [N-1:0][1:0]        e_size;
   logic [N-1:0][PFN_W-1:0]  e_pfn;

   logic [N-1:0]     lk_hit, inv_hit, fl_hit, fl_dup;
   logic [IDX_W-1:0] fl_slot, sel_idx;
   logic             sel_hit;

   tlb_tag_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
      .ent_valid(e_valid), .ent_glb(e_glb), .ent_vpn(e_vpn), .ent_asid(e_asid),
      .ent_size(e_size), .key_vpn(lk_va[VA_W-1:OFS_W]), .key_asid(lk_asid),
      .any_asid(!tag_en), .hit(lk_hit));

   tlb_tag_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_inv_match (
      .ent_valid(e_valid), .ent_glb(e_glb), .ent_vpn(e_vpn), .ent_asid(e_asid),
      .ent_size(e_size), .key_vpn(inv_vpn), .key_asid(inv_asid),
      .any_asid(!tag_en), .hit(inv_hit));

   tlb_tag_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fl_match (
      .ent_valid(e_valid), .ent_glb(e_glb), .ent_vpn(e_vpn), .ent_asid(e_asid),
      .ent_size(e_size), .key_vpn(fl_vpn), .key_asid(fl_asid),
      .any_asid(!tag_en), .hit(fl_hit));

   for (genvar g = 0; g < N; g++) begin : g_dup
      assign fl_dup[g] = fl_hit[g] && (e_size[g] == fl_size) && (e_glb[g] == fl_global);
   end

   tlb_victim_sel #(.N(N)) u_victim (
      .clk(clk), .rst_n(rst_n), .ent_valid(e_valid), .dup_hit(fl_dup),
      .take(fl_valid), .slot(fl_slot));

   // lowest matching entry answers the lookup
   always_comb begin
      sel_idx = '0;
      sel_hit = 1'b0;
      for (int i = N-1; i >= 0; i--) begin
         if (lk_hit[i]) begin
            sel_idx = IDX_W'(i);
            sel_hit = 1'b1;
         end
      end
   end

   logic [PA_W-1:0] pa_n;
   logic [PFN_W-1:0] sel_pfn;
   assign sel_pfn = e_pfn[sel_idx];

   always_comb begin
      case (e_size[sel_idx])
         PG_2M:   pa_n = {sel_pfn[PFN_W-1:MID_DROP], lk_va[OFS_W+MID_DROP-1:0]};
         PG_1G:   pa_n = {sel_pfn[PFN_W-1:TOP_DROP], lk_va[OFS_W+TOP_DROP-1:0]};
         default: pa_n = {sel_pfn, lk_va[OFS_W-1:0]};
      endcase
   end

   logic take_rsp;
   assign take_rsp = lk_valid && sel_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_pa    <= '0;
         rsp_rw    <= 1'b0;
         rsp_us    <= 1'b0;
         rsp_nx    <= 1'b0;
         rsp_dirty <= 1'b0;
         rsp_deny  <= 1'b0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= take_rsp;
         rsp_pa    <= take_rsp ? pa_n : '0;
         rsp_rw    <= take_rsp && e_rw[sel_idx];
         rsp_us    <= take_rsp && e_us[sel_idx];
         rsp_nx    <= take_rsp && e_nx[sel_idx];
         rsp_dirty <= take_rsp && e_dirty[sel_idx];
         rsp_deny  <= take_rsp && ((lk_write && !e_rw[sel_idx]) ||
                                   (lk_user  && !e_us[sel_idx]) ||
                                   (lk_exec  &&  e_nx[sel_idx]));
      end
   end

   // table update: removals first, the fill lands last
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_valid <= '0;
         e_glb   <= '0;
         e_rw    <= '0;
         e_us    <= '0;
         e_nx    <= '0;
         e_dirty <= '0;
         e_vpn   <= '0;
         e_asid  <= '0;
         e_size  <= '0;
         e_pfn   <= '0;
      end else begin
         for (int i = 0; i < N; i++) begin
            if (sw_valid && !tag_en && !e_glb[i])
               e_valid[i] <= 1'b0;
            if (inv_valid) begin
               case (inv_kind)
                  INV_PAGE:  if (inv_hit[i]) e_valid[i] <= 1'b0;
                  INV_SPACE: if (!e_glb[i] && (e_asid[i] == inv_asid)) e_valid[i] <= 1'b0;
                  INV_EVERY: e_valid[i] <= 1'b0;
                  default:   ;
               endcase
            end
            if (fl_valid && (fl_slot == IDX_W'(i))) begin
               e_valid[i] <= 1'b1;
               e_glb[i]   <= fl_global;
               e_vpn[i]   <= fl_vpn;
               e_asid[i]  <= fl_asid;
               e_size[i]  <= fl_size;
               e_pfn[i]   <= fl_pfn;
               e_rw[i]    <= fl_rw;
               e_us[i]    <= fl_us;
               e_nx[i]    <= fl_nx;
               e_dirty[i] <= fl_dirty;
            end
         end
      end
   end
endmodule

// File: rtl/tagged_tlb_chk.sv
module tagged_tlb_chk #(
   parameter int N      = 16,
   parameter int VPN_W  = 36,
   parameter int ASID_W = 12,
   parameter int PFN_W  = 40,
   parameter int OFS_W  = 12,
   localparam int VA_W  = VPN_W + OFS_W,
   localparam int PA_W  = PFN_W + OFS_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tag_en,
   input logic              lk_valid,
   input logic [VA_W-1:0]   lk_va,
   input logic [ASID_W-1:0] lk_asid,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic [PA_W-1:0]   rsp_pa,
   input logic              rsp_deny,
   input logic              fl_valid,
   input logic [VPN_W-1:0]  fl_vpn,
   input logic [ASID_W-1:0] fl_asid,
   input logic [1:0]        fl_size,
   input logic              inv_valid,
   input logic [1:0]        inv_kind,
   input logic              sw_valid,
   input logic [N-1:0]      e_valid,
   input logic [N-1:0]      e_glb
);
   p_rsp_due_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);

   p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid);

   p_miss_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_pa == '0 && !rsp_deny));

   p_deny_on_hit_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_deny |-> (rsp_hit && rsp_valid));

   p_fill_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_valid && !inv_valid && !sw_valid && fl_size == 2'd0) ##1
      (lk_valid && lk_va[VA_W-1:OFS_W] == $past(fl_vpn) && lk_asid == $past(fl_asid))
      |=> rsp_hit);

   p_flush_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && inv_kind == 2'd2 && !fl_valid) ##1 lk_valid |=> !rsp_hit);

   p_switch_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_valid && tag_en && !inv_valid && !fl_valid) |=> (e_valid == $past(e_valid)));

   p_space_keeps_global_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && inv_kind == 2'd1 && !fl_valid && !sw_valid)
      |=> ((e_valid & e_glb) == $past(e_valid & e_glb)));
endmodule

bind tagged_tlb tagged_tlb_chk #(
   .N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W), .OFS_W(OFS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tag_en(tag_en), .lk_valid(lk_valid), .lk_va(lk_va),
   .lk_asid(lk_asid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa),
   .rsp_deny(rsp_deny), .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_asid(fl_asid),
   .fl_size(fl_size), .inv_valid(inv_valid), .inv_kind(inv_kind), .sw_valid(sw_valid),
   .e_valid(e_valid), .e_glb(e_glb)
);

// File: tb/tagged_tlb_bench.sv
module tagged_tlb_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tag_en = 1'b1;
   logic        lk_valid = 1'b0;
   logic [47:0] lk_va = '0;
   logic [11:0] lk_asid = '0;
   logic        lk_write = 1'b0, lk_user = 1'b0, lk_exec = 1'b0;
   logic        rsp_valid, rsp_hit, rsp_rw, rsp_us, rsp_nx, rsp_dirty, rsp_deny;
   logic [51:0] rsp_pa;
   logic        fl_valid = 1'b0;
   logic [35:0] fl_vpn = '0;
   logic [11:0] fl_asid = '0;
   logic        fl_global = 1'b0;
   logic [1:0]  fl_size = '0;
   logic [39:0] fl_pfn = '0;
   logic        fl_rw = 1'b0, fl_us = 1'b0, fl_nx = 1'b0, fl_dirty = 1'b0;
   logic        inv_valid = 1'b0;
   logic [1:0]  inv_kind = 2'd3;
   logic [35:0] inv_vpn = '0;
   logic [11:0] inv_asid = '0;
   logic        sw_valid = 1'b0;

   int errors = 0;
   int checks = 0;
   string cur_tag = "R3";

   always #5 clk = ~clk;

   tagged_tlb u_tagged_tlb (
      .clk(clk), .rst_n(rst_n), .tag_en(tag_en), .lk_valid(lk_valid), .lk_va(lk_va),
      .lk_asid(lk_asid), .lk_write(lk_write), .lk_user(lk_user), .lk_exec(lk_exec),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa), .rsp_rw(rsp_rw),
      .rsp_us(rsp_us), .rsp_nx(rsp_nx), .rsp_dirty(rsp_dirty), .rsp_deny(rsp_deny),
      .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_asid(fl_asid), .fl_global(fl_global),
      .fl_size(fl_size), .fl_pfn(fl_pfn), .fl_rw(fl_rw), .fl_us(fl_us), .fl_nx(fl_nx),
      .fl_dirty(fl_dirty), .inv_valid(inv_valid), .inv_kind(inv_kind), .inv_vpn(inv_vpn),
      .inv_asid(inv_asid), .sw_valid(sw_valid));

   // behavioural reference table
   bit          m_v[16];
   bit          m_g[16];
   logic [35:0] m_vpn[16];
   logic [11:0] m_asid[16];
   logic [1:0]  m_size[16];
   logic [39:0] m_pfn[16];
   bit          m_rw[16], m_us[16], m_nx[16], m_d[16];
   int          m_rr = 0;

   function automatic bit m_eq(int i, logic [35:0] vpn);
      case (m_size[i])
         2'd0:    return m_vpn[i] == vpn;
         2'd1:    return m_vpn[i][35:9] == vpn[35:9];
         2'd2:    return m_vpn[i][35:18] == vpn[35:18];
         default: return 1'b0;
      endcase
   endfunction

   function automatic int m_find(logic [35:0] vpn, logic [11:0] asid);
      for (int i = 0; i < 16; i++)
         if (m_v[i] && m_eq(i, vpn) && (m_g[i] || !tag_en || m_asid[i] == asid))
            return i;
      return -1;
   endfunction

   function automatic void m_update();
      int slot = -1;
      if (fl_valid) begin
         for (int i = 0; i < 16; i++)
            if (slot < 0 && m_v[i] && m_eq(i, fl_vpn) && m_size[i] == fl_size &&
                m_g[i] == fl_global && (m_g[i] || !tag_en || m_asid[i] == fl_asid))
               slot = i;
         for (int i = 0; i < 16; i++)
            if (slot < 0 && !m_v[i]) slot = i;
         if (slot < 0) begin
            slot = m_rr;
            m_rr = (m_rr + 1) % 16;
         end
      end
      for (int i = 0; i < 16; i++) begin
         if (sw_valid && !tag_en && !m_g[i]) m_v[i] = 1'b0;
         if (inv_valid) begin
            if (inv_kind == 2'd0 && m_v[i] && m_eq(i, inv_vpn) &&
                (m_g[i] || !tag_en || m_asid[i] == inv_asid)) m_v[i] = 1'b0;
            if (inv_kind == 2'd1 && !m_g[i] && m_asid[i] == inv_asid) m_v[i] = 1'b0;
            if (inv_kind == 2'd2) m_v[i] = 1'b0;
         end
      end
      if (slot >= 0) begin
         m_v[slot] = 1'b1;     m_g[slot] = fl_global; m_vpn[slot] = fl_vpn;
         m_asid[slot] = fl_asid; m_size[slot] = fl_size; m_pfn[slot] = fl_pfn;
         m_rw[slot] = fl_rw;   m_us[slot] = fl_us;    m_nx[slot] = fl_nx;
         m_d[slot] = fl_dirty;
      end
   endfunction

   task automatic step();
      bit          ev = lk_valid;
      int          k = -1;
      bit          e_hit = 0, e_rw = 0, e_us = 0, e_nx = 0, e_d = 0, e_deny = 0;
      logic [51:0] e_pa = '0;
      if (ev) begin
         k = m_find(lk_va[47:12], lk_asid);
         if (k >= 0) begin
            e_hit = 1;
            e_rw = m_rw[k]; e_us = m_us[k]; e_nx = m_nx[k]; e_d = m_d[k];
            case (m_size[k])
               2'd1:    e_pa = {m_pfn[k][39:9], lk_va[20:0]};
               2'd2:    e_pa = {m_pfn[k][39:18], lk_va[29:0]};
               default: e_pa = {m_pfn[k], lk_va[11:0]};
            endcase
            e_deny = (lk_write && !e_rw) || (lk_user && !e_us) || (lk_exec && e_nx);
         end
      end
      @(posedge clk);
      m_update();
      @(negedge clk);
      checks++;
      if (rsp_valid !== ev) begin
         errors++;
         $display("FAIL R1 rsp_valid actual=%b expected=%b", rsp_valid, ev);
      end
      if (ev) begin
         checks++;
         if (rsp_hit !== e_hit || rsp_pa !== e_pa || rsp_rw !== e_rw || rsp_us !== e_us ||
             rsp_nx !== e_nx || rsp_dirty !== e_d || rsp_deny !== e_deny) begin
            errors++;
            $display("FAIL %s actual hit=%b pa=%h p=%b%b%b%b deny=%b expected hit=%b pa=%h p=%b%b%b%b deny=%b",
                     cur_tag, rsp_hit, rsp_pa, rsp_rw, rsp_us, rsp_nx, rsp_dirty, rsp_deny,
                     e_hit, e_pa, e_rw, e_us, e_nx, e_d, e_deny);
         end
      end
   endtask

   task automatic look(input logic [47:0] va, input logic [11:0] asid,
                       input bit w, input bit u, input bit x, input string tag);
      lk_valid = 1; lk_va = va; lk_asid = asid; lk_write = w; lk_user = u; lk_exec = x;
      cur_tag = tag;
      step();
      lk_valid = 0; lk_write = 0; lk_user = 0; lk_exec = 0;
   endtask

   task automatic set_fill(input logic [35:0] vpn, input logic [11:0] asid, input bit g,
                           input logic [1:0] sz, input logic [39:0] pfn,
                           input bit rw, input bit us, input bit nx, input bit d);
      fl_valid = 1; fl_vpn = vpn; fl_asid = asid; fl_global = g; fl_size = sz;
      fl_pfn = pfn; fl_rw = rw; fl_us = us; fl_nx = nx; fl_dirty = d;
   endtask

   task automatic fill(input logic [35:0] vpn, input logic [11:0] asid, input bit g,
                       input logic [1:0] sz, input logic [39:0] pfn,
                       input bit rw, input bit us, input bit nx, input bit d);
      set_fill(vpn, asid, g, sz, pfn, rw, us, nx, d);
      step();
      fl_valid = 0;
   endtask

   task automatic inval(input logic [1:0] kind, input logic [35:0] vpn, input logic [11:0] asid);
      inv_valid = 1; inv_kind = kind; inv_vpn = vpn; inv_asid = asid;
      step();
      inv_valid = 0; inv_kind = 2'd3;
   endtask

   task automatic switch_root();
      sw_valid = 1;
      step();
      sw_valid = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset actual=%b%b expected=00", rsp_valid, rsp_hit);
      end
      rst_n = 1;
      @(negedge clk);
      // R3: empty after reset
      look({36'h0_0000_0123, 12'h456}, 12'd5, 0, 0, 0, "R3");
      // R13 then R2: fill and lookup same cycle, then visible
      set_fill(36'h0_0000_0123, 12'd5, 0, 2'd0, 40'hAB_CDEF_0123, 1, 1, 0, 1);
      look({36'h0_0000_0123, 12'h456}, 12'd5, 0, 0, 0, "R13");
      fl_valid = 0;
      look({36'h0_0000_0123, 12'h456}, 12'd5, 1, 1, 0, "R2");
      look({36'h0_0000_0123, 12'hFFF}, 12'd6, 0, 0, 0, "R2");
      look({36'h0_0000_0124, 12'h000}, 12'd5, 0, 0, 0, "R3");
      // R4: global entry
      fill(36'h8_0000_0777, 12'd0, 1, 2'd0, 40'h00_0000_4444, 0, 0, 1, 0);
      look({36'h8_0000_0777, 12'h010}, 12'd9, 0, 0, 0, "R4");
      // R12: permission faults
      look({36'h8_0000_0777, 12'h010}, 12'd9, 1, 0, 0, "R12");
      look({36'h8_0000_0777, 12'h010}, 12'd9, 0, 1, 0, "R12");
      look({36'h8_0000_0777, 12'h010}, 12'd9, 0, 0, 1, "R12");
      look({36'h0_0000_0123, 12'h010}, 12'd5, 0, 0, 1, "R12");
      // R11: large pages
      fill(36'h1_2345_6000, 12'd5, 0, 2'd1, 40'h12_3456_79FF, 1, 1, 0, 0);
      look({36'h1_2345_61AB, 12'hCDE}, 12'd5, 0, 0, 0, "R11");
      look({36'h1_2345_6200, 12'hCDE}, 12'd5, 0, 0, 0, "R11");
      fill(36'h2_4000_0000, 12'd5, 0, 2'd2, 40'h55_5554_0000, 1, 1, 0, 0);
      look({36'h2_4003_FFFF, 12'h321}, 12'd5, 0, 0, 0, "R11");
      look({36'h2_4004_0000, 12'h321}, 12'd5, 0, 0, 0, "R11");
      // R5: switch behaviour in both modes
      switch_root();
      look({36'h0_0000_0123, 12'h001}, 12'd5, 0, 0, 0, "R5");
      tag_en = 0;
      look({36'h0_0000_0123, 12'h001}, 12'd6, 0, 0, 0, "R5");
      switch_root();
      look({36'h0_0000_0123, 12'h001}, 12'd5, 0, 0, 0, "R5");
      look({36'h8_0000_0777, 12'h001}, 12'd5, 0, 0, 0, "R5");
      tag_en = 1;
      // R6: page invalidate under one tag
      fill(36'h0_0000_0AAA, 12'd5, 0, 2'd0, 40'h00_0000_1111, 1, 1, 0, 0);
      fill(36'h0_0000_0AAA, 12'd7, 0, 2'd0, 40'h00_0000_2222, 1, 1, 0, 0);
      fill(36'h0_0000_0AAB, 12'd5, 0, 2'd0, 40'h00_0000_3333, 1, 1, 0, 0);
      inval(2'd0, 36'h0_0000_0AAA, 12'd5);
      look({36'h0_0000_0AAA, 12'h000}, 12'd5, 0, 0, 0, "R6");
      look({36'h0_0000_0AAA, 12'h000}, 12'd7, 0, 0, 0, "R6");
      look({36'h0_0000_0AAB, 12'h000}, 12'd5, 0, 0, 0, "R6");
      // R7: address-space invalidate keeps global
      inval(2'd1, 36'h0, 12'd7);
      look({36'h0_0000_0AAA, 12'h000}, 12'd7, 0, 0, 0, "R7");
      look({36'h8_0000_0777, 12'h000}, 12'd7, 0, 0, 0, "R7");
      look({36'h0_0000_0AAB, 12'h000}, 12'd5, 0, 0, 0, "R7");
      // R8: no-op kind then everything
      inval(2'd3, 36'h0, 12'd5);
      look({36'h0_0000_0AAB, 12'h000}, 12'd5, 0, 0, 0, "R8");
      inval(2'd2, 36'h0, 12'd0);
      look({36'h8_0000_0777, 12'h000}, 12'd3, 0, 0, 0, "R8");
      look({36'h0_0000_0AAB, 12'h000}, 12'd5, 0, 0, 0, "R8");
      // R9: fill all slots, then round-robin replacement
      for (int i = 0; i < 16; i++)
         fill(36'h100 + 36'(i), 12'd1, 0, 2'd0, 40'h1000 + 40'(i), 1, 1, 0, 0);
      for (int i = 0; i < 16; i++)
         look({36'h100 + 36'(i), 12'h0}, 12'd1, 0, 0, 0, "R9");
      fill(36'h200, 12'd1, 0, 2'd0, 40'h2000, 1, 1, 0, 0);
      look({36'h100, 12'h0}, 12'd1, 0, 0, 0, "R9");
      look({36'h200, 12'h0}, 12'd1, 0, 0, 0, "R9");
      fill(36'h201, 12'd1, 0, 2'd0, 40'h2001, 1, 1, 0, 0);
      look({36'h101, 12'h0}, 12'd1, 0, 0, 0, "R9");
      // R10: refill of a present key updates in place
      fill(36'h105, 12'd1, 0, 2'd0, 40'hF105, 0, 1, 1, 1);
      look({36'h105, 12'h7}, 12'd1, 0, 0, 0, "R10");
      look({36'h102, 12'h7}, 12'd1, 0, 0, 0, "R10");
      fill(36'h202, 12'd1, 0, 2'd0, 40'h2002, 1, 1, 0, 0);
      look({36'h102, 12'h7}, 12'd1, 0, 0, 0, "R10");
      look({36'h103, 12'h7}, 12'd1, 0, 0, 0, "R10");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule